// File: doc/BRIEF.md
# Display Controller Interrupt Status Unit

This unit gathers the event strobes of a multi-channel display controller's frame fetch and timing logic into two status words. It masks them, raises one level interrupt, and records which channel's frame ID caused the first unmasked event. The main status word carries global events and the events of channel 0. The secondary word carries start-of-frame, end-of-frame, branch and underrun events for channels 1 to NCH-1. Software clears status by writing ones.

The unit also owns the controller's enable bit. Dropping the enable by a control write is reported as a quick-disable event. If the stop-at-frame-end option is set, the enable clears by itself when the current frame ends, and a last-frame-done event is raised.

When an unmasked channel event or a bus error arrives while the interrupt is low, the frame ID of that channel is latched. When the interrupt is already high, a "further interrupt" flag is set instead, and the latched ID keeps its value.

Top module: `disp_irq_status`

## Requirements
- R1: After reset, both status words, both mask words, the latched ID, the enable output and the interrupt are all zero.
- R2: Main status bit positions: 0 last-frame-done, 1 channel-0 frame start, 2 bus error, 3 AC-bias count, 4 channel-0 underrun, 5 channel-1 underrun, 6 output underrun, 7 quick-disable, 8 channel-0 frame end, 9 channel-0 branch, 10 further-interrupt flag, 11 read status, 12 command done.
- R3: For channel n, with n from 1 to NCH-1, secondary status sets bit n-1 on frame start, n+7 on frame end and n+15 on branch. For n of 2 or more, it sets bit n+23 on underrun. The channel-1 underrun is reported only in main bit 5.
- R4: The interrupt is a register. Each clock it takes the OR of the main bits 0,1,4,5,6,7,8,9,11 and 12 whose main mask bit is clear, with the secondary bits whose secondary mask bit is clear. It follows a status change one clock later. Bits 2, 3 and 10 never raise it.
- R5: A masked event still sets its status bit. It raises neither the interrupt nor an ID capture.
- R6: Frame start, frame end and branch events with a clear mask, and every bus error, are capturing events. On a capturing event while the interrupt is low, the ID of the selected channel is latched. A bus error is selected before any other event, and otherwise the lowest channel is selected. On a capturing event while the interrupt is high, main bit 10 is set and the ID holds.
- R7: A bus error sets main bit 2 and writes its channel number into main bits 30:28, whatever the masks are.
- R8: A write with wr_sel=3 clears the main bits that are set in wr_data[11:0]. A one in bit 2 also zeroes bits 30:28. Bits 12 and up are not cleared. An event arriving in the same cycle as a clear wins.
- R9: A write with wr_sel=4 clears secondary bits in wr_data AND 0x003E3F3F only. All other secondary bits stay set until reset.
- R10: A write with wr_sel=0 loads bit 0 as enable and bit 1 as stop-at-frame-end. A write that drops the enable from 1 to 0 sets main bit 7.
- R11: frame_end with enable and stop-at-frame-end both set clears the enable and sets main bit 0. Without the stop option, the enable stays.
- R12: wr_sel=1 loads the main mask and wr_sel=2 loads the secondary mask. Each mask bit masks the status bit at the same position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Write target: 0 control, 1 main mask, 2 secondary mask, 3 main clear, 4 secondary clear |
| wr_data | input | 32 | Write data |
| frame_end | input | 1 | End of the current display frame |
| ev_sof | input | NCH | Per-channel frame-start strobe |
| ev_eof | input | NCH | Per-channel frame-end strobe |
| ev_branch | input | NCH | Per-channel branch strobe |
| ev_underrun | input | NCH | Per-channel input underrun strobe |
| ev_acbias | input | 1 | AC-bias count event |
| ev_outrun | input | 1 | Output underrun event |
| ev_rdstat | input | 1 | Read status event |
| ev_cmd | input | 1 | Command done event |
| berr_valid | input | 1 | Bus error strobe |
| berr_ch | input | 3 | Channel of the bus error |
| ch_id | input | NCH*IDW | Current frame ID of each channel, channel 0 in the low bits |
| disp_en | output | 1 | Controller enable |
| main_status | output | 32 | Main status word |
| sec_status | output | 32 | Secondary status word |
| irq_id | output | IDW | Latched frame ID |
| irq | output | 1 | Level interrupt |

## Verification
A status bit latched at the wrong position, or cleared by the wrong write bit, shows on the status ports at the first falling clock edge after the strobe. A wrong mask gate or a wrong interrupt source set shows on irq one clock later. A wrong capture decision shows on irq_id in that same cycle. Because the further-interrupt flag and the ID are mutually exclusive outcomes of a capture, an interrupt register that is one cycle off swaps which of the two moves.

// File: rtl/dirq_pkg.sv
// Shared constants for the display interrupt status unit: register
// selectors, main status bit positions and the set of interrupt sources.
package dirq_pkg;
    typedef enum logic [2:0] {
        SEL_CTRL  = 3'd0,
        SEL_MMASK = 3'd1,
        SEL_SMASK = 3'd2,
        SEL_MCLR  = 3'd3,
        SEL_SCLR  = 3'd4
    } reg_sel_e;

    localparam int B_LDD   = 0;
    localparam int B_SOF0  = 1;
    localparam int B_BERR  = 2;
    localparam int B_ACB   = 3;
    localparam int B_UND0  = 4;
    localparam int B_UND1  = 5;
    localparam int B_OUT   = 6;
    localparam int B_QDIS  = 7;
    localparam int B_EOF0  = 8;
    localparam int B_BR0   = 9;
    localparam int B_MORE  = 10;
    localparam int B_RDST  = 11;
    localparam int B_CMD   = 12;
    localparam int N_FLAGS = 13;
    localparam int FLD_LSB = 28;
    localparam int CH_W    = 3;

    // Main bits allowed to raise the interrupt line
    localparam logic [31:0] MAIN_IRQ_SRC = 32'h0000_1BF3;
endpackage

// File: rtl/dirq_ctrl.sv
// Control and mask registers. Holds enable, stop-at-frame-end and both
// mask words; emits one-cycle quick-disable and last-frame-done strobes.
// Assumes one write per cycle; a control write outranks the auto-stop.
module dirq_ctrl
    import dirq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [2:0]  wr_sel,
    input  logic [31:0] wr_data,
    input  logic        frame_end,
    output logic        en_o,
    output logic [31:0] main_mask_o,
    output logic [31:0] sec_mask_o,
    output logic        qdis_set,
    output logic        ldd_set
);
    logic stop_q;
    logic ctrl_wr;

    assign ctrl_wr  = wr_en && (wr_sel == SEL_CTRL);
    assign qdis_set = ctrl_wr && en_o && !wr_data[0];
    assign ldd_set  = !ctrl_wr && frame_end && en_o && stop_q;

    // Enable and stop option: software load, or auto-clear at frame end
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_o   <= 1'b0;
            stop_q <= 1'b0;
        end else if (ctrl_wr) begin
            en_o   <= wr_data[0];
            stop_q <= wr_data[1];
        end else if (ldd_set) begin
            en_o   <= 1'b0;
        end
    end

    // Mask words loaded by software
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            main_mask_o <= '0;
            sec_mask_o  <= '0;
        end else if (wr_en && wr_sel == SEL_MMASK) begin
            main_mask_o <= wr_data;
        end else if (wr_en && wr_sel == SEL_SMASK) begin
            sec_mask_o  <= wr_data;
        end
    end
endmodule

// File: rtl/dirq_main_status.sv
// Main status word: thirteen event flags plus the bus-error channel field.
// Write-one-to-clear on bits 11:0; a new event in the same cycle wins.
module dirq_main_status
    import dirq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_FLAGS-1:0] set_bits,
    input  logic               berr_valid,
    input  logic [CH_W-1:0]    berr_ch,
    input  logic               clr_en,
    input  logic [11:0]        clr_data,
    output logic [31:0]        status_o
);
    logic [N_FLAGS-1:0] flags_q;
    logic [CH_W-1:0]    field_q;
    logic [N_FLAGS-1:0] clr_vec;

    assign clr_vec  = clr_en ? {1'b0, clr_data} : '0;
    assign status_o = {1'b0, field_q, {(FLD_LSB-N_FLAGS){1'b0}}, flags_q};

    // Event flags: clear then set, so a same-cycle event survives
    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= (flags_q & ~clr_vec) | set_bits;
    end

    // Faulting channel: loaded by a bus error, zeroed by clearing bit 2
    always_ff @(posedge clk) begin
        if (!rst_n)                            field_q <= '0;
        else if (berr_valid)                   field_q <= berr_ch;
        else if (clr_en && clr_data[B_BERR])   field_q <= '0;
    end
endmodule

// File: rtl/dirq_sec_status.sv
// Secondary status word for channels 1..NCH-1. Each channel owns four
// positions spaced by eight; software may clear only CLR_MASK bits.
module dirq_sec_status #(
    parameter int          NCH      = 7,
    parameter logic [31:0] CLR_MASK = 32'h003E_3F3F
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] sof,
    input  logic [NCH-1:0] eof,
    input  logic [NCH-1:0] branch,
    input  logic [NCH-1:0] underrun,
    input  logic           clr_en,
    input  logic [31:0]    clr_data,
    output logic [31:0]    status_o
);
    logic [31:0] set_vec;
    logic [31:0] clr_vec;

    // Map the per-channel strobes onto their bit positions
    always_comb begin
        set_vec = '0;
        for (int n = 1; n < NCH; n++) begin
            set_vec[n-1]  = sof[n];
            set_vec[n+7]  = eof[n];
            set_vec[n+15] = branch[n];
            if (n >= 2) set_vec[n+23] = underrun[n];
        end
    end

    assign clr_vec = clr_en ? (clr_data & CLR_MASK) : '0;

    // Status word: clear selected bits, then merge new events
    always_ff @(posedge clk) begin
        if (!rst_n) status_o <= '0;
        else        status_o <= (status_o & ~clr_vec) | set_vec;
    end
endmodule

// File: rtl/dirq_id_capture.sv
// Source identification. Picks the bus-error channel, else the lowest
// channel with an unmasked event; latches its frame ID while the interrupt
// is low, otherwise requests the further-interrupt flag.
module dirq_id_capture #(
    parameter int NCH = 7,
    parameter int IDW = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NCH-1:0]     hit,
    input  logic               berr_valid,
    input  logic [2:0]         berr_ch,
    input  logic               irq,
    input  logic [NCH*IDW-1:0] ch_id,
    output logic [IDW-1:0]     id_o,
    output logic               more_set
);
    logic any;
    int   sel;

    // Priority select: bus error first, then lowest channel number
    always_comb begin
        sel = 0;
        for (int n = NCH - 1; n >= 0; n--) begin
            if (hit[n]) sel = n;
        end
        if (berr_valid) sel = int'(berr_ch);
    end

    assign any      = berr_valid || (|hit);
    assign more_set = any && irq;

    // ID register: written only by the first source while the line is low
    always_ff @(posedge clk) begin
        if (!rst_n)                          id_o <= '0;
        else if (any && !irq && sel < NCH)   id_o <= ch_id[sel*IDW +: IDW];
    end
endmodule

// File: rtl/disp_irq_status.sv
// Top of the display interrupt status unit. Routes event strobes into the
// two status words, gates them with the masks into a registered interrupt
// and drives source identification. Assumes strobes are one-cycle pulses.
module disp_irq_status
    import dirq_pkg::*;
#(
    parameter int          NCH          = 7,
    parameter int          IDW          = 16,
    parameter logic [31:0] SEC_CLR_MASK = 32'h003E_3F3F
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [2:0]         wr_sel,
    input  logic [31:0]        wr_data,
    input  logic               frame_end,
    input  logic [NCH-1:0]     ev_sof,
    input  logic [NCH-1:0]     ev_eof,
    input  logic [NCH-1:0]     ev_branch,
    input  logic [NCH-1:0]     ev_underrun,
    input  logic               ev_acbias,
    input  logic               ev_outrun,
    input  logic               ev_rdstat,
    input  logic               ev_cmd,
    input  logic               berr_valid,
    input  logic [2:0]         berr_ch,
    input  logic [NCH*IDW-1:0] ch_id,
    output logic               disp_en,
    output logic [31:0]        main_status,
    output logic [31:0]        sec_status,
    output logic [IDW-1:0]     irq_id,
    output logic               irq
);
    logic [31:0]        main_mask;
    logic [31:0]        sec_mask;
    logic               qdis_set;
    logic               ldd_set;
    logic               more_set;
    logic [NCH-1:0]     hit;
    logic [N_FLAGS-1:0] main_set;

    dirq_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_sel      (wr_sel),
        .wr_data     (wr_data),
        .frame_end   (frame_end),
        .en_o        (disp_en),
        .main_mask_o (main_mask),
        .sec_mask_o  (sec_mask),
        .qdis_set    (qdis_set),
        .ldd_set     (ldd_set)
    );

    // Main event vector assembled at fixed bit positions
    always_comb begin
        main_set          = '0;
        main_set[B_LDD]   = ldd_set;
        main_set[B_SOF0]  = ev_sof[0];
        main_set[B_BERR]  = berr_valid;
        main_set[B_ACB]   = ev_acbias;
        main_set[B_UND0]  = ev_underrun[0];
        main_set[B_UND1]  = ev_underrun[1];
        main_set[B_OUT]   = ev_outrun;
        main_set[B_QDIS]  = qdis_set;
        main_set[B_EOF0]  = ev_eof[0];
        main_set[B_BR0]   = ev_branch[0];
        main_set[B_MORE]  = more_set;
        main_set[B_RDST]  = ev_rdstat;
        main_set[B_CMD]   = ev_cmd;
    end

    dirq_main_status u_main (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_bits   (main_set),
        .berr_valid (berr_valid),
        .berr_ch    (berr_ch),
        .clr_en     (wr_en && wr_sel == SEL_MCLR),
        .clr_data   (wr_data[11:0]),
        .status_o   (main_status)
    );

    dirq_sec_status #(.NCH(NCH), .CLR_MASK(SEC_CLR_MASK)) u_sec (
        .clk      (clk),
        .rst_n    (rst_n),
        .sof      (ev_sof),
        .eof      (ev_eof),
        .branch   (ev_branch),
        .underrun (ev_underrun),
        .clr_en   (wr_en && wr_sel == SEL_SCLR),
        .clr_data (wr_data),
        .status_o (sec_status)
    );

    // Unmasked capturing events per channel; channel 0 uses the main mask
    assign hit[0] = (ev_sof[0]    & ~main_mask[B_SOF0]) |
                    (ev_eof[0]    & ~main_mask[B_EOF0]) |
                    (ev_branch[0] & ~main_mask[B_BR0]);
    for (genvar n = 1; n < NCH; n++) begin : g_hit
        assign hit[n] = (ev_sof[n]    & ~sec_mask[n-1])  |
                        (ev_eof[n]    & ~sec_mask[n+7])  |
                        (ev_branch[n] & ~sec_mask[n+15]);
    end

    dirq_id_capture #(.NCH(NCH), .IDW(IDW)) u_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .hit        (hit),
        .berr_valid (berr_valid),
        .berr_ch    (berr_ch),
        .irq        (irq),
        .ch_id      (ch_id),
        .id_o       (irq_id),
        .more_set   (more_set)
    );

    // Interrupt line: registered OR of unmasked source bits
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= (|(main_status & ~main_mask & MAIN_IRQ_SRC)) |
                           (|(sec_status & ~sec_mask));
    end
endmodule

// File: rtl/dirq_checker.sv
// Property checker for disp_irq_status, attached by bind. Observes ports
// and the mask registers; holds no state of its own.
module dirq_checker
    import dirq_pkg::*;
#(
    parameter int          IDW          = 16,
    parameter logic [31:0] SEC_CLR_MASK = 32'h003E_3F3F
) (
    input logic           clk,
    input logic           rst_n,
    input logic           wr_en,
    input logic [2:0]     wr_sel,
    input logic [31:0]    wr_data,
    input logic           berr_valid,
    input logic [2:0]     berr_ch,
    input logic           disp_en,
    input logic [31:0]    main_status,
    input logic [31:0]    sec_status,
    input logic [31:0]    main_mask,
    input logic [31:0]    sec_mask,
    input logic [IDW-1:0] irq_id,
    input logic           irq
);
    assert_irq_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> irq == ((|($past(main_status) & ~$past(main_mask) & MAIN_IRQ_SRC)) |
                                 (|($past(sec_status) & ~$past(sec_mask)))));

    assert_id_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> $stable(irq_id));

    assert_berr_field_R7: assert property (@(posedge clk) disable iff (!rst_n)
        berr_valid |=> main_status[B_BERR] && main_status[30:28] == $past(berr_ch));

    assert_sec_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (($past(sec_status) & ~SEC_CLR_MASK & ~sec_status) == 32'h0));

    assert_quick_disable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_CTRL && !wr_data[0] && disp_en) |=> main_status[B_QDIS]);
endmodule

bind disp_irq_status dirq_checker #(.IDW(IDW), .SEC_CLR_MASK(SEC_CLR_MASK)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_sel      (wr_sel),
    .wr_data     (wr_data),
    .berr_valid  (berr_valid),
    .berr_ch     (berr_ch),
    .disp_en     (disp_en),
    .main_status (main_status),
    .sec_status  (sec_status),
    .main_mask   (main_mask),
    .sec_mask    (sec_mask),
    .irq_id      (irq_id),
    .irq         (irq)
);

// File: tb/disp_irq_status_bench.sv
module disp_irq_status_bench;
    localparam int NCH = 7;
    localparam int IDW = 16;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               wr_en = 1'b0;
    logic [2:0]         wr_sel = '0;
    logic [31:0]        wr_data = '0;
    logic               frame_end = 1'b0;
    logic [NCH-1:0]     ev_sof = '0, ev_eof = '0, ev_branch = '0, ev_underrun = '0;
    logic               ev_acbias = 1'b0, ev_outrun = 1'b0, ev_rdstat = 1'b0, ev_cmd = 1'b0;
    logic               berr_valid = 1'b0;
    logic [2:0]         berr_ch = '0;
    logic [NCH*IDW-1:0] ch_id;
    logic               disp_en, irq;
    logic [31:0]        main_status, sec_status;
    logic [IDW-1:0]     irq_id;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    always #5 clk = ~clk;

    disp_irq_status #(.NCH(NCH), .IDW(IDW)) u_disp_irq_status (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .frame_end(frame_end), .ev_sof(ev_sof), .ev_eof(ev_eof), .ev_branch(ev_branch),
        .ev_underrun(ev_underrun), .ev_acbias(ev_acbias), .ev_outrun(ev_outrun),
        .ev_rdstat(ev_rdstat), .ev_cmd(ev_cmd), .berr_valid(berr_valid), .berr_ch(berr_ch),
        .ch_id(ch_id), .disp_en(disp_en), .main_status(main_status),
        .sec_status(sec_status), .irq_id(irq_id), .irq(irq)
    );

    // Vector: channel(3) kind(2: 0 start,1 end,2 branch,3 underrun) main(32) sec(32)
    localparam int NV = 12;
    localparam logic [68:0] VEC [NV] = '{
        {3'd0, 2'd0, 32'h0000_0002, 32'h0000_0000},
        {3'd0, 2'd1, 32'h0000_0100, 32'h0000_0000},
        {3'd0, 2'd2, 32'h0000_0200, 32'h0000_0000},
        {3'd0, 2'd3, 32'h0000_0010, 32'h0000_0000},
        {3'd1, 2'd3, 32'h0000_0020, 32'h0000_0000},
        {3'd1, 2'd0, 32'h0000_0000, 32'h0000_0001},
        {3'd3, 2'd0, 32'h0000_0000, 32'h0000_0004},
        {3'd3, 2'd1, 32'h0000_0000, 32'h0000_0400},
        {3'd6, 2'd1, 32'h0000_0000, 32'h0000_2000},
        {3'd5, 2'd2, 32'h0000_0000, 32'h0010_0000},
        {3'd6, 2'd2, 32'h0000_0000, 32'h0020_0000},
        {3'd2, 2'd2, 32'h0000_0000, 32'h0002_0000}
    };

    function automatic logic [IDW-1:0] id_of(int ch);
        return IDW'(16'hA000 + ch * 16'h0111);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic reg_wr(logic [2:0] sel, logic [31:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic clear_all();
        reg_wr(3'd3, 32'h0000_0FFF);
        reg_wr(3'd4, 32'hFFFF_FFFF);
        @(negedge clk);
    endtask

    // Drive one strobe for one cycle; returns at the negedge after its edge
    task automatic pulse(int kind, int ch);
        @(negedge clk);
        case (kind)
            0: ev_sof[ch] = 1'b1;
            1: ev_eof[ch] = 1'b1;
            2: ev_branch[ch] = 1'b1;
            default: ev_underrun[ch] = 1'b1;
        endcase
        @(negedge clk);
        ev_sof = '0; ev_eof = '0; ev_branch = '0; ev_underrun = '0;
    endtask

    initial begin
        for (int c = 0; c < NCH; c++) ch_id[c*IDW +: IDW] = id_of(c);
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [IDW-1:0] exp_id;
        exp_id = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 main", main_status, 32'h0);
        chk("R1 sec", sec_status, 32'h0);
        chk("R1 id", 32'(irq_id), 32'h0);
        chk("R1 irq", 32'(irq), 32'h0);
        chk("R1 en", 32'(disp_en), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table: R2/R3 positions, R4 one-cycle irq, R6 capture, R8/R9 clear
        for (int v = 0; v < NV; v++) begin
            int ch, kind;
            ch = int'(VEC[v][68:66]);
            kind = int'(VEC[v][65:64]);
            pulse(kind, ch);
            if (kind < 3) exp_id = id_of(ch);
            chk("R2 main position", main_status, VEC[v][63:32]);
            chk("R3 sec position", sec_status, VEC[v][31:0]);
            @(negedge clk);
            chk("R4 irq raised", 32'(irq), 32'h1);
            chk("R6 id captured", 32'(irq_id), 32'(exp_id));
            clear_all();
            chk("R8 R9 irq after clear", 32'(irq), 32'h0);
        end

        // R5 masked event: status set, no irq, no capture
        reg_wr(3'd1, 32'h0000_0002);
        pulse(0, 0);
        chk("R5 masked status", main_status, 32'h2);
        repeat (2) @(negedge clk);
        chk("R5 masked irq", 32'(irq), 32'h0);
        chk("R5 masked id", 32'(irq_id), 32'(exp_id));
        reg_wr(3'd1, 32'h0);
        clear_all();

        // R6 further-interrupt flag while irq is high
        pulse(1, 4);
        chk("R6 first id", 32'(irq_id), 32'(id_of(4)));
        @(negedge clk);
        chk("R4 irq high", 32'(irq), 32'h1);
        pulse(0, 2);
        chk("R6 more flag", main_status, 32'h0000_0400);
        chk("R6 id held", 32'(irq_id), 32'(id_of(4)));
        chk("R3 both sec", sec_status, 32'h0000_0802);

        // R7 bus error under full masks; R4 bus error is no source
        reg_wr(3'd1, 32'hFFFF_FFFF);
        reg_wr(3'd2, 32'hFFFF_FFFF);
        clear_all();
        @(negedge clk);
        berr_valid = 1'b1; berr_ch = 3'd5;
        @(negedge clk);
        berr_valid = 1'b0;
        chk("R7 berr status", main_status, 32'h5000_0004);
        chk("R7 berr id", 32'(irq_id), 32'(id_of(5)));
        reg_wr(3'd1, 32'h0);
        reg_wr(3'd2, 32'h0);
        repeat (2) @(negedge clk);
        chk("R4 berr no irq", 32'(irq), 32'h0);
        reg_wr(3'd3, 32'h0000_0FFB);
        chk("R8 field kept", main_status, 32'h5000_0004);
        reg_wr(3'd3, 32'h0000_0004);
        chk("R8 field cleared", main_status, 32'h0);

        // R4 AC-bias event never raises irq
        @(negedge clk); ev_acbias = 1'b1;
        @(negedge clk); ev_acbias = 1'b0;
        chk("R2 acbias bit", main_status, 32'h8);
        repeat (2) @(negedge clk);
        chk("R4 acbias no irq", 32'(irq), 32'h0);
        clear_all();

        // R10 quick disable
        reg_wr(3'd0, 32'h1);
        chk("R10 enable set", 32'(disp_en), 32'h1);
        reg_wr(3'd0, 32'h0);
        chk("R10 enable off", 32'(disp_en), 32'h0);
        chk("R10 qdis bit", main_status, 32'h80);
        @(negedge clk);
        chk("R10 qdis irq", 32'(irq), 32'h1);
        clear_all();

        // R11 stop at frame end
        reg_wr(3'd0, 32'h1);
        @(negedge clk); frame_end = 1'b1;
        @(negedge clk); frame_end = 1'b0;
        chk("R11 no stop keeps en", 32'(disp_en), 32'h1);
        chk("R11 no stop no ldd", main_status, 32'h0);
        reg_wr(3'd0, 32'h3);
        @(negedge clk); frame_end = 1'b1;
        @(negedge clk); frame_end = 1'b0;
        chk("R11 auto stop", 32'(disp_en), 32'h0);
        chk("R11 ldd bit", main_status, 32'h1);
        clear_all();

        // R8 set wins over same-cycle clear
        @(negedge clk);
        ev_eof[0] = 1'b1; wr_en = 1'b1; wr_sel = 3'd3; wr_data = 32'h100;
        @(negedge clk);
        ev_eof[0] = 1'b0; wr_en = 1'b0;
        chk("R8 set wins", main_status, 32'h100);
        clear_all();

        // R9 sticky secondary bit; R8 bit 12 not clearable
        pulse(2, 1);
        reg_wr(3'd4, 32'hFFFF_FFFF);
        chk("R9 sticky sec", sec_status, 32'h0001_0000);
        @(negedge clk); ev_cmd = 1'b1;
        @(negedge clk); ev_cmd = 1'b0;
        reg_wr(3'd3, 32'hFFFF_FFFF);
        chk("R8 bit12 kept", main_status, 32'h0000_1000);
        chk("R9 irq held", 32'(irq), 32'h1);

        // R12 mask write gates sticky sources; R1 reset clears everything
        reg_wr(3'd1, 32'h0000_1000);
        reg_wr(3'd2, 32'h0001_0000);
        @(negedge clk);
        chk("R12 masks drop irq", 32'(irq), 32'h0);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1 reset main", main_status, 32'h0);
        chk("R1 reset sec", sec_status, 32'h0);
        chk("R1 reset irq", 32'(irq), 32'h0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule